// File: doc/BRIEF.md
# Instruction Decoder to Datapath Control Word

This block is a purely combinational decoder for a compact 16-bit instruction set. One instruction word goes in. Out come a packed 16-bit control word that steers a register-file-plus-ALU datapath, an extended immediate operand, and the branch controls that a separate program-counter unit needs. The control word selects the destination register, the two source registers, whether operand B comes from the register file or from the immediate, the ALU function, whether the write-back value comes from memory or from the ALU, and whether the register file is written. A memory write strobe marks store instructions.

Because the block holds no state, its outputs follow the instruction word in the same cycle. The enclosing pipeline registers them where its timing requires. Any opcode that is not part of the set raises an illegal flag. In that case the decoder makes every side effect inert: no register write, no memory write, and no branch.

Top module: `insn_ctrl_decoder`

## Requirements
- R1: The instruction word is split as opcode = bits 15:9, RD = bits 8:6, RA = bits 5:3, RB = bits 2:0. The control word is packed from MSB to LSB as dest[15:13], srcA[12:10], srcB[9:7], imm_sel[6], alu[5:2], mem_sel[1], reg_we[0].
- R2: Register-register opcodes give dest=RD, srcA=RA, srcB=RB, imm_sel=0, mem_sel=0, reg_we=1 and imm=0. Their alu codes are: ADD 0000000→0000, SUB 0000001→0001, INC 0000010→0010, DCR 0000011→0011, AND 0001001→0100, OR 0001010→0101, MOV 0000111→0111 (pass A).
- R3: LD (1010000) gives dest=RD, srcA=RA, srcB=RB, imm_sel=1, alu=0000, mem_sel=1, reg_we=1, and imm = bits 2:0 zero-filled.
- R4: ST (1100000) gives dest=0, srcA=RA, srcB=RD (the data register), imm_sel=1, alu=0000, mem_sel=0, reg_we=0, mem_we=1, and imm = bits 2:0 zero-filled.
- R5: LDI (0110111) gives dest=RD, srcA=0, srcB=0, imm_sel=1, alu=1000 (pass B), mem_sel=0, reg_we=1, and imm = bits 5:0 sign-extended.
- R6: ADI (0010000) and SUI.U (0010001) give dest=RD, srcA=RA, srcB=0, imm_sel=1, mem_sel=0, reg_we=1. ADI uses alu=0000 with bits 2:0 sign-extended. SUI.U uses alu=0001 with bits 2:0 zero-filled.
- R7: BZ (1110000) and BNZ (1110001) give br_kind 01 and 10 respectively. The offset is {bits 8:6, bits 2:0} sign-extended. The control word has srcA=RA, alu=0111 and every other field 0, and imm=0.
- R8: JMP (1111000) gives br_kind=11, br_off = bits 8:0 sign-extended, an all-zero control word and imm=0.
- R9: Every other opcode raises illegal and forces the control word, imm, br_off, br_kind and mem_we to 0. Every listed opcode leaves illegal at 0.
- R10: mem_we is 1 only for ST. All non-branch instructions give br_kind=00 and br_off=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 16 | Instruction word |
| ctrl_word | output | 16 | Packed datapath control word |
| imm | output | DATA_W | Extended immediate operand |
| br_off | output | OFF_W | Sign-extended PC-relative offset |
| br_kind | output | 2 | 00 none, 01 if zero, 10 if nonzero, 11 always |
| mem_we | output | 1 | Memory write strobe (stores) |
| illegal | output | 1 | Opcode not in the set |

## Verification
Every output is a combinational function of the instruction word alone, so each result is due within the same cycle as the word that produces it, with zero register stages on the way. The bench changes the instruction on the falling clock edge and samples all six outputs one nanosecond later. Each sample therefore sees the settled value of exactly one instruction. The sweep covers all 65,536 instruction words, so every operand combination of every opcode and every illegal encoding is compared.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

  localparam int INSN_W = 16;
  localparam int OPC_W  = 7;
  localparam int REG_W  = 3;
  localparam int ALU_W  = 4;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD    = 4'h0,
    ALU_SUB    = 4'h1,
    ALU_INC    = 4'h2,
    ALU_DEC    = 4'h3,
    ALU_AND    = 4'h4,
    ALU_OR     = 4'h5,
    ALU_PASS_A = 4'h7,
    ALU_PASS_B = 4'h8
  } alu_op_e;

  typedef enum logic [3:0] {
    K_REG, K_LD, K_ST, K_LDI, K_ADI, K_SUI, K_BZ, K_BNZ, K_JMP, K_BAD
  } insn_kind_e;

  typedef enum logic [1:0] {
    BR_NONE   = 2'b00,
    BR_ZERO   = 2'b01,
    BR_NZERO  = 2'b10,
    BR_ALWAYS = 2'b11
  } br_kind_e;

  typedef struct packed {
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] src_b;
    logic             imm_sel;
    logic [ALU_W-1:0] alu;
    logic             mem_sel;
    logic             reg_we;
  } ctrl_word_t;

endpackage

// File: rtl/insn_opcode_map.sv
module insn_opcode_map
  import insn_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output insn_kind_e       kind,
  output alu_op_e          alu
);

  always_comb begin
    kind = K_BAD;
    alu  = ALU_ADD;
    unique case (opc)
      7'b0000000: begin kind = K_REG; alu = ALU_ADD;    end
      7'b0000001: begin kind = K_REG; alu = ALU_SUB;    end
      7'b0000010: begin kind = K_REG; alu = ALU_INC;    end
      7'b0000011: begin kind = K_REG; alu = ALU_DEC;    end
      7'b0000111: begin kind = K_REG; alu = ALU_PASS_A; end
      7'b0001001: begin kind = K_REG; alu = ALU_AND;    end
      7'b0001010: begin kind = K_REG; alu = ALU_OR;     end
      7'b1010000: begin kind = K_LD;  alu = ALU_ADD;    end
      7'b1100000: begin kind = K_ST;  alu = ALU_ADD;    end
      7'b0110111: begin kind = K_LDI; alu = ALU_PASS_B; end
      7'b0010000: begin kind = K_ADI; alu = ALU_ADD;    end
      7'b0010001: begin kind = K_SUI; alu = ALU_SUB;    end
      7'b1110000: begin kind = K_BZ;  alu = ALU_PASS_A; end
      7'b1110001: begin kind = K_BNZ; alu = ALU_PASS_A; end
      7'b1111000: begin kind = K_JMP; alu = ALU_ADD;    end
      default:    begin kind = K_BAD; alu = ALU_ADD;    end
    endcase
  end

endmodule

// File: rtl/insn_imm_extend.sv
module insn_imm_extend
  import insn_dec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  insn_kind_e        kind,
  input  logic [5:0]        fld,
  output logic [DATA_W-1:0] imm
);

  localparam int PAD6 = DATA_W - 6;
  localparam int PAD3 = DATA_W - 3;

  logic [DATA_W-1:0] sx6, sx3, zf3;

  assign sx6 = {{PAD6{fld[5]}}, fld};
  assign sx3 = {{PAD3{fld[2]}}, fld[2:0]};
  assign zf3 = {{PAD3{1'b0}},   fld[2:0]};

  always_comb begin
    unique case (kind)
      K_LDI:             imm = sx6;
      K_ADI:             imm = sx3;
      K_SUI, K_LD, K_ST: imm = zf3;
      default:           imm = '0;
    endcase
  end

endmodule

// File: rtl/insn_branch_fields.sv
module insn_branch_fields
  import insn_dec_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  insn_kind_e       kind,
  input  logic [8:0]       lo9,
  output br_kind_e         br_kind,
  output logic [OFF_W-1:0] br_off
);

  localparam int PAD6 = OFF_W - 6;
  localparam int PAD9 = OFF_W - 9;

  logic [5:0]       split6;
  logic [OFF_W-1:0] cond_off, jump_off;

  assign split6   = {lo9[8:6], lo9[2:0]};
  assign cond_off = {{PAD6{split6[5]}}, split6};
  assign jump_off = {{PAD9{lo9[8]}}, lo9};

  always_comb begin
    br_kind = BR_NONE;
    br_off  = '0;
    unique case (kind)
      K_BZ:    begin br_kind = BR_ZERO;   br_off = cond_off; end
      K_BNZ:   begin br_kind = BR_NZERO;  br_off = cond_off; end
      K_JMP:   begin br_kind = BR_ALWAYS; br_off = jump_off; end
      default: begin br_kind = BR_NONE;   br_off = '0;       end
    endcase
  end

endmodule

// File: rtl/insn_ctrl_decoder.sv
module insn_ctrl_decoder
  import insn_dec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 16
) (
  input  logic [15:0]       insn,
  output logic [15:0]       ctrl_word,
  output logic [DATA_W-1:0] imm,
  output logic [OFF_W-1:0]  br_off,
  output logic [1:0]        br_kind,
  output logic              mem_we,
  output logic              illegal
);

  logic [OPC_W-1:0] opc;
  logic [REG_W-1:0] f_rd, f_ra, f_rb;
  insn_kind_e       kind;
  alu_op_e          alu;
  br_kind_e         bk;
  ctrl_word_t       cw;

  assign opc  = insn[15:9];
  assign f_rd = insn[8:6];
  assign f_ra = insn[5:3];
  assign f_rb = insn[2:0];

  insn_opcode_map u_map (
    .opc  (opc),
    .kind (kind),
    .alu  (alu)
  );

  insn_imm_extend #(.DATA_W(DATA_W)) u_imm (
    .kind (kind),
    .fld  (insn[5:0]),
    .imm  (imm)
  );

  insn_branch_fields #(.OFF_W(OFF_W)) u_br (
    .kind    (kind),
    .lo9     (insn[8:0]),
    .br_kind (bk),
    .br_off  (br_off)
  );

  always_comb begin
    cw     = '0;
    cw.alu = alu;
    unique case (kind)
      K_REG: begin
        cw.dst = f_rd; cw.src_a = f_ra; cw.src_b = f_rb; cw.reg_we = 1'b1;
      end
      K_LD: begin
        cw.dst = f_rd; cw.src_a = f_ra; cw.src_b = f_rb;
        cw.imm_sel = 1'b1; cw.mem_sel = 1'b1; cw.reg_we = 1'b1;
      end
      K_ST: begin
        cw.src_a = f_ra; cw.src_b = f_rd; cw.imm_sel = 1'b1;
      end
      K_LDI: begin
        cw.dst = f_rd; cw.imm_sel = 1'b1; cw.reg_we = 1'b1;
      end
      K_ADI, K_SUI: begin
        cw.dst = f_rd; cw.src_a = f_ra; cw.imm_sel = 1'b1; cw.reg_we = 1'b1;
      end
      K_BZ, K_BNZ: begin
        cw.src_a = f_ra;
      end
      default: cw = '0;
    endcase
  end

  assign ctrl_word = cw;
  assign br_kind   = bk;
  assign mem_we    = (kind == K_ST);
  assign illegal   = (kind == K_BAD);

endmodule

// File: rtl/insn_ctrl_decoder_chk.sv
module insn_ctrl_decoder_chk #(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 16
) (
  input logic [15:0]       insn,
  input logic [15:0]       ctrl_word,
  input logic [DATA_W-1:0] imm,
  input logic [OFF_W-1:0]  br_off,
  input logic [1:0]        br_kind,
  input logic              mem_we,
  input logic              illegal
);

  always_comb begin
    if (!$isunknown(insn)) begin
      assert_illegal_inert_R9: assert (!illegal ||
        (ctrl_word == '0 && imm == '0 && br_off == '0 && br_kind == 2'b00 && !mem_we))
        else $error("illegal opcode left a side effect");
      assert_store_only_memwrite_R10: assert (mem_we == (insn[15:9] == 7'b1100000))
        else $error("mem_we mismatch with store opcode");
      assert_branch_no_write_R7: assert (br_kind == 2'b00 || !ctrl_word[0])
        else $error("branch writes register");
      assert_load_uses_imm_R3: assert (!ctrl_word[1] || (ctrl_word[6] && ctrl_word[0]))
        else $error("memory select without immediate or write");
      assert_dest_is_rd_R1: assert (!ctrl_word[0] || ctrl_word[15:13] == insn[8:6])
        else $error("written register is not RD");
    end
  end

endmodule

bind insn_ctrl_decoder insn_ctrl_decoder_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W)) i_chk (
  .insn      (insn),
  .ctrl_word (ctrl_word),
  .imm       (imm),
  .br_off    (br_off),
  .br_kind   (br_kind),
  .mem_we    (mem_we),
  .illegal   (illegal)
);

// File: tb/test_insn_ctrl_decoder.sv
`timescale 1ns/1ps
module test_insn_ctrl_decoder;

  localparam int DW = 16;
  localparam int OW = 16;

  logic          clk;
  logic          rst_n;
  logic [15:0]   insn;
  logic [15:0]   ctrl_word;
  logic [DW-1:0] imm;
  logic [OW-1:0] br_off;
  logic [1:0]    br_kind;
  logic          mem_we;
  logic          illegal;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  insn_ctrl_decoder #(.DATA_W(DW), .OFF_W(OW)) i_insn_ctrl_decoder (
    .insn(insn), .ctrl_word(ctrl_word), .imm(imm), .br_off(br_off),
    .br_kind(br_kind), .mem_we(mem_we), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0]   e_cw;
  logic [DW-1:0] e_imm;
  logic [OW-1:0] e_off;
  logic [1:0]    e_bk;
  logic          e_we, e_ill;
  string         tag;

  task automatic expect_for(input logic [15:0] w);
    logic [6:0] opc;
    logic [2:0] rd, ra, rb;
    opc = w[15:9]; rd = w[8:6]; ra = w[5:3]; rb = w[2:0];
    e_cw = '0; e_imm = '0; e_off = '0; e_bk = 2'b00; e_we = 1'b0; e_ill = 1'b0;
    tag = "R2";
    case (opc)
      7'b0000000: e_cw = {rd, ra, rb, 1'b0, 4'h0, 1'b0, 1'b1};
      7'b0000001: e_cw = {rd, ra, rb, 1'b0, 4'h1, 1'b0, 1'b1};
      7'b0000010: e_cw = {rd, ra, rb, 1'b0, 4'h2, 1'b0, 1'b1};
      7'b0000011: e_cw = {rd, ra, rb, 1'b0, 4'h3, 1'b0, 1'b1};
      7'b0001001: e_cw = {rd, ra, rb, 1'b0, 4'h4, 1'b0, 1'b1};
      7'b0001010: e_cw = {rd, ra, rb, 1'b0, 4'h5, 1'b0, 1'b1};
      7'b0000111: e_cw = {rd, ra, rb, 1'b0, 4'h7, 1'b0, 1'b1};
      7'b1010000: begin tag = "R3";
        e_cw = {rd, ra, rb, 1'b1, 4'h0, 1'b1, 1'b1}; e_imm = DW'(rb); end
      7'b1100000: begin tag = "R4";
        e_cw = {3'd0, ra, rd, 1'b1, 4'h0, 1'b0, 1'b0}; e_imm = DW'(rb); e_we = 1'b1; end
      7'b0110111: begin tag = "R5";
        e_cw = {rd, 3'd0, 3'd0, 1'b1, 4'h8, 1'b0, 1'b1};
        e_imm = DW'($signed(w[5:0])); end
      7'b0010000: begin tag = "R6";
        e_cw = {rd, ra, 3'd0, 1'b1, 4'h0, 1'b0, 1'b1}; e_imm = DW'($signed(rb)); end
      7'b0010001: begin tag = "R6";
        e_cw = {rd, ra, 3'd0, 1'b1, 4'h1, 1'b0, 1'b1}; e_imm = DW'(rb); end
      7'b1110000: begin tag = "R7";
        e_cw = {3'd0, ra, 3'd0, 1'b0, 4'h7, 1'b0, 1'b0}; e_bk = 2'b01;
        e_off = OW'($signed({rd, rb})); end
      7'b1110001: begin tag = "R7";
        e_cw = {3'd0, ra, 3'd0, 1'b0, 4'h7, 1'b0, 1'b0}; e_bk = 2'b10;
        e_off = OW'($signed({rd, rb})); end
      7'b1111000: begin tag = "R8";
        e_bk = 2'b11; e_off = OW'($signed(w[8:0])); end
      default: begin tag = "R9"; e_ill = 1'b1; end
    endcase
  endtask

  task automatic cmp(input string what, input string req, input logic [31:0] act,
                     input logic [31:0] exp, input logic [15:0] w);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      if (n_bad <= 40)
        $display("FAIL %s %s insn=%h actual=%h expected=%h", req, what, w, act, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    insn  = 16'h0000;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // Initial state: word 0000 is ADD R0,R0,R0 (R1/R2 packing, R9 legal)
    #1;
    cmp("ctrl_word@start", "R1", 32'(ctrl_word), 32'h0001, insn);
    cmp("illegal@start", "R9", 32'(illegal), 32'h0, insn);
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      insn = i[15:0];
      #1;
      expect_for(insn);
      cmp("ctrl_word", tag, 32'(ctrl_word), 32'(e_cw), insn);
      cmp("imm", tag, 32'(imm), 32'(e_imm), insn);
      cmp("br_off", (tag == "R7" || tag == "R8") ? tag : "R10", 32'(br_off), 32'(e_off), insn);
      cmp("br_kind", (tag == "R7" || tag == "R8") ? tag : "R10", 32'(br_kind), 32'(e_bk), insn);
      cmp("mem_we", "R10", 32'(mem_we), 32'(e_we), insn);
      cmp("illegal", "R9", 32'(illegal), 32'(e_ill), insn);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule